// File: doc/BRIEF.md
# Source-Routed Port-Stripping Switch Stage

This block is one hop of a source-routed network. The sender places the whole route in the first flit of a message. The route is a sequence of fixed-width output port numbers. The field in the most significant bits belongs to the switch that sees the message first. The stage computes no route. It reads the leading field of the first flit and uses it to select one of its outputs. It then removes that field by shifting the flit left by one field width, so the next stage finds its own port number at the top. Every later flit of the message goes out unchanged to the same output, up to and including the flit marked last.

The input is a single valid/ready stream with a last-flit marker. Each output has its own valid and ready, and all outputs share one data bus and one last bus. The stage stores no flits: the accepting output's ready passes straight back to the input. If a header names a port that does not exist, the stage accepts and discards the whole message and raises an error flag that stays set until reset. Stages can be connected in a chain, with an output of one stage driving the input of the next.

Top module: `swr_switch`

## Requirements
- R1: The leading route field is bits [DATA_W-1 -: PORT_W] of the first flit of a message. Its value k, when k < N_OUT, selects output k. Only out_valid[k] carries that message.
- R2: On the selected output, the first flit appears as the input flit shifted left by PORT_W bits, with the low PORT_W bits set to zero.
- R3: Every flit after the first goes out on the output chosen by the header, with data and last unchanged. The choice does not change until the flit marked last has been accepted.
- R4: At most one out_valid bit is high in any cycle. No out_valid bit is high unless in_valid is high.
- R5: A first flit whose route field is N_OUT or more causes the whole message, through its last flit, to be accepted (in_ready high) without any out_valid being raised.
- R6: err_flag is 0 after reset. It becomes 1 in the cycle after a header with an out-of-range route field is accepted, and stays 1 until reset.
- R7: While a message is being forwarded, in_ready equals the selected output's out_ready. A flit held under backpressure is delivered exactly once, without loss.
- R8: The flit after an accepted last flit is treated as a new header. This applies also when a message is a single flit, with its header flit marked last.
- R9: During and after reset, with no input offered, all out_valid bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted when high together with in_valid |
| in_data | input | DATA_W | Input flit |
| in_last | input | 1 | Marks the final flit of a message |
| out_valid | output | N_OUT | Per-output flit valid |
| out_ready | input | N_OUT | Per-output ready |
| out_data | output | DATA_W | Shared output flit data |
| out_last | output | 1 | Shared output last marker |
| err_flag | output | 1 | Sticky flag for an out-of-range route field |

## Verification
The bench builds every stage with DATA_W=32, PORT_W=2 and N_OUT=3. This leaves exactly one route code, 3, that names no output, so the drop path and the sticky flag can be reached with an ordinary header. With a two-bit field, a chain of three stages consumes six header bits. The final header can then be compared with the original header shifted by six bits. Random per-output ready lets held flits cross message boundaries, and a stretch with ready forced low shows that the stage holds a header under backpressure.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;
  // Message tracking state of one switch stage.
  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,  // next accepted flit is a header
    ST_FWD  = 2'd1,  // body flits go to the locked output
    ST_DROP = 2'd2   // body flits are consumed and discarded
  } swr_state_e;
endpackage

// File: rtl/swr_route_decode.sv
`timescale 1ns/1ps
module swr_route_decode #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 2,
  parameter int N_OUT  = 3
) (
  input  logic [DATA_W-1:0] flit,
  output logic [PORT_W-1:0] port,
  output logic              port_ok,
  output logic [DATA_W-1:0] stripped
);
  localparam int LOW_W = DATA_W - PORT_W;

  // Leading route field sits at the top of the first flit.
  function automatic logic [PORT_W-1:0] lead_field(input logic [DATA_W-1:0] f);
    return f[DATA_W-1 -: PORT_W];
  endfunction

  // Remove the leading field: move the rest up, zero-fill the bottom.
  function automatic logic [DATA_W-1:0] drop_lead(input logic [DATA_W-1:0] f);
    return {f[LOW_W-1:0], {PORT_W{1'b0}}};
  endfunction

  function automatic logic in_range(input logic [PORT_W-1:0] p);
    return 32'(p) < N_OUT;
  endfunction

  always_comb begin
    port     = lead_field(flit);
    port_ok  = in_range(port);
    stripped = drop_lead(flit);
  end
endmodule

// File: rtl/swr_msg_state.sv
`timescale 1ns/1ps
module swr_msg_state #(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,      // flit accepted this cycle
  input  logic              last,      // accepted flit ends the message
  input  logic [PORT_W-1:0] hdr_port,  // decoded route field
  input  logic              hdr_ok,    // route field names a real output
  output swr_pkg::swr_state_e state_q,
  output logic [PORT_W-1:0] port_q,
  output logic              err_q
);
  import swr_pkg::*;

  logic hdr_fire;
  assign hdr_fire = fire && (state_q == ST_HEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HEAD;
      port_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (hdr_fire) begin
        port_q <= hdr_port;
        if (!hdr_ok) err_q <= 1'b1;
        if (!last) state_q <= hdr_ok ? ST_FWD : ST_DROP;
      end else if (fire && last) begin
        state_q <= ST_HEAD;
      end
    end
  end
endmodule

// File: rtl/swr_out_demux.sv
`timescale 1ns/1ps
module swr_out_demux #(
  parameter int N_OUT  = 3,
  parameter int PORT_W = 2
) (
  input  logic              fwd_en,   // flit is to be forwarded, not dropped
  input  logic              in_valid,
  input  logic [PORT_W-1:0] sel,
  input  logic [N_OUT-1:0]  out_ready,
  output logic [N_OUT-1:0]  out_valid,
  output logic              sel_ready
);
  logic [N_OUT-1:0] hit;

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    assign hit[k]       = fwd_en && (32'(sel) == k);
    assign out_valid[k] = hit[k] && in_valid;
  end

  assign sel_ready = |(hit & out_ready);
endmodule

// File: rtl/swr_switch.sv
`timescale 1ns/1ps
module swr_switch #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 2,
  parameter int N_OUT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [N_OUT-1:0]  out_valid,
  input  logic [N_OUT-1:0]  out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              err_flag
);
  import swr_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [PORT_W-1:0] hdr_port;
  logic              hdr_ok;
  logic [DATA_W-1:0] hdr_stripped;
  swr_state_e        state_q;
  logic [PORT_W-1:0] port_q;
  logic              head;
  logic              dropping;
  logic [PORT_W-1:0] cur_port;
  logic              sel_ready;
  logic              fire;

  swr_route_decode #(.DATA_W(DATA_W), .PORT_W(PORT_W), .N_OUT(N_OUT)) u_dec (
    .flit     (in_data),
    .port     (hdr_port),
    .port_ok  (hdr_ok),
    .stripped (hdr_stripped)
  );

  assign head     = (state_q == ST_HEAD);
  assign dropping = head ? !hdr_ok : (state_q == ST_DROP);
  assign cur_port = head ? hdr_port : port_q;

  swr_out_demux #(.N_OUT(N_OUT), .PORT_W(PORT_W)) u_dmx (
    .fwd_en    (!dropping),
    .in_valid  (in_valid),
    .sel       (cur_port),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .sel_ready (sel_ready)
  );

  assign in_ready = dropping ? 1'b1 : sel_ready;
  assign fire     = in_valid && in_ready;
  assign out_data = head ? hdr_stripped : in_data;
  assign out_last = in_last;

  swr_msg_state #(.PORT_W(PORT_W)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .last     (in_last),
    .hdr_port (hdr_port),
    .hdr_ok   (hdr_ok),
    .state_q  (state_q),
    .port_q   (port_q),
    .err_q    (err_flag)
  );
endmodule

// File: rtl/swr_switch_chk.sv
`timescale 1ns/1ps
module swr_switch_chk #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 2,
  parameter int N_OUT  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_last,
  input logic [N_OUT-1:0]  out_valid,
  input logic [N_OUT-1:0]  out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err_flag,
  input logic              head,
  input logic              dropping,
  input logic              hdr_ok,
  input logic [PORT_W-1:0] port_q
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_single_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));
  p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> in_valid);
  p_header_strip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (head && (|out_valid)) |-> (out_data == (in_data << PORT_W)));
  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> (out_valid == '0));
  p_drop_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && in_valid) |-> in_ready);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (head && fire && !hdr_ok) |=> err_flag);
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!head && !(fire && in_last)) |=> (!head && $stable(port_q)));
  p_ready_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dropping) |-> (in_ready == |(out_valid & out_ready)));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_last) |=> head);
endmodule

bind swr_switch swr_switch_chk #(.DATA_W(DATA_W), .PORT_W(PORT_W), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err_flag  (err_flag),
  .head      (head),
  .dropping  (dropping),
  .hdr_ok    (hdr_ok),
  .port_q    (port_q)
);

// File: tb/sim_swr_switch.sv
`timescale 1ns/1ps
module sim_swr_switch;
  localparam int DW = 32;
  localparam int PW = 2;
  localparam int NO = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz
  logic rst_n = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic [PW-1:0] port;
    logic [DW-1:0] data;
    logic          last;
  } item_t;
  item_t exp_q[$];
  item_t chain_q[$];

  // ---------------- single stage u0 ----------------
  logic          d_valid = 1'b0;
  logic          d_ready;
  logic [DW-1:0] d_data = '0;
  logic          d_last = 1'b0;
  logic [NO-1:0] o_valid;
  logic [NO-1:0] o_ready;
  logic [DW-1:0] o_data;
  logic          o_last;
  logic          o_err;
  bit            bp = 1'b0;
  bit            hold = 1'b0;

  swr_switch #(.DATA_W(DW), .PORT_W(PW), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(d_valid), .in_ready(d_ready), .in_data(d_data), .in_last(d_last),
    .out_valid(o_valid), .out_ready(o_ready), .out_data(o_data), .out_last(o_last),
    .err_flag(o_err)
  );

  always @(negedge clk) o_ready <= hold ? '0 : (bp ? NO'($urandom) : '1);

  // ---------------- three-stage chain ----------------
  logic          c_valid = 1'b0;
  logic          c_ready;
  logic [DW-1:0] c_data = '0;
  logic          c_last = 1'b0;
  logic [NO-1:0] a_valid, b_valid, z_valid;
  logic [DW-1:0] a_data, b_data, z_data;
  logic          a_last, b_last, z_last;
  logic          b_in_ready, z_in_ready;
  logic          a_err, b_err, z_err;

  swr_switch #(.DATA_W(DW), .PORT_W(PW), .N_OUT(NO)) u_hop1 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(c_valid), .in_ready(c_ready), .in_data(c_data), .in_last(c_last),
    .out_valid(a_valid), .out_ready({1'b1, b_in_ready, 1'b1}),
    .out_data(a_data), .out_last(a_last), .err_flag(a_err)
  );
  swr_switch #(.DATA_W(DW), .PORT_W(PW), .N_OUT(NO)) u_hop2 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(a_valid[1]), .in_ready(b_in_ready), .in_data(a_data), .in_last(a_last),
    .out_valid(b_valid), .out_ready({z_in_ready, 1'b1, 1'b1}),
    .out_data(b_data), .out_last(b_last), .err_flag(b_err)
  );
  swr_switch #(.DATA_W(DW), .PORT_W(PW), .N_OUT(NO)) u_hop3 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(b_valid[2]), .in_ready(z_in_ready), .in_data(b_data), .in_last(b_last),
    .out_valid(z_valid), .out_ready(3'b111),
    .out_data(z_data), .out_last(z_last), .err_flag(z_err)
  );

  // ---------------- check helper ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- monitors (sample between edges) ----------------
  initial forever begin
    @(negedge clk); #3;
    if (rst_n && (|(o_valid & o_ready))) begin
      chk($countones(o_valid) == 1, "R4", "one output valid", DW'(o_valid), 32'd1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected output flit", o_data, '0);
      end else begin
        item_t e;
        int k;
        e = exp_q.pop_front();
        k = -1;
        for (int i = 0; i < NO; i++) if (o_valid[i]) k = i;
        chk(k == int'(e.port), "R1", "output port", DW'(k), DW'(e.port));
        chk(o_data == e.data, "R2/R3", "output data", o_data, e.data);
        chk(o_last == e.last, "R3", "output last", DW'(o_last), DW'(e.last));
      end
    end
  end

  initial forever begin
    @(negedge clk); #3;
    if (rst_n && z_valid[0]) begin
      if (chain_q.size() == 0) begin
        chk(1'b0, "R1", "chain unexpected flit", z_data, '0);
      end else begin
        item_t e;
        e = chain_q.pop_front();
        chk(z_data == e.data, "R2", "chain data", z_data, e.data);
        chk(z_last == e.last, "R3", "chain last", DW'(z_last), DW'(e.last));
      end
    end
    if (rst_n) chk(z_valid[2:1] == 2'b00 && a_valid[2] == 1'b0 && a_valid[0] == 1'b0,
                   "R1", "chain stray output", DW'({a_valid, z_valid}), '0);
  end

  // ---------------- drivers ----------------
  task automatic send_flit(input logic [DW-1:0] d, input logic l);
    bit go;
    @(negedge clk);
    d_valid = 1'b1; d_data = d; d_last = l;
    do begin
      #2; go = d_ready;
      @(posedge clk);
      if (!go) @(negedge clk);
    end while (!go);
  endtask

  task automatic send_msg(input logic [DW-1:0] hdr, input int nbody, input logic [DW-1:0] base);
    logic [PW-1:0] p;
    p = hdr[DW-1 -: PW];
    if (int'(p) < NO) begin
      exp_q.push_back('{p, hdr << PW, nbody == 0});
      for (int i = 0; i < nbody; i++)
        exp_q.push_back('{p, base + DW'(i), i == nbody - 1});
    end
    send_flit(hdr, nbody == 0);
    for (int i = 0; i < nbody; i++) send_flit(base + DW'(i), i == nbody - 1);
    @(negedge clk); d_valid = 1'b0;
  endtask

  task automatic send_chain(input logic [DW-1:0] hdr, input int nbody, input logic [DW-1:0] base);
    bit go;
    chain_q.push_back('{2'd0, hdr << (3 * PW), nbody == 0});
    for (int i = 0; i < nbody; i++) chain_q.push_back('{2'd0, base + DW'(i), i == nbody - 1});
    for (int i = 0; i <= nbody; i++) begin
      @(negedge clk);
      c_valid = 1'b1;
      c_data  = (i == 0) ? hdr : base + DW'(i - 1);
      c_last  = (i == nbody);
      do begin
        #2; go = c_ready;
        @(posedge clk);
        if (!go) @(negedge clk);
      end while (!go);
    end
    @(negedge clk); c_valid = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && (exp_q.size() != 0 || chain_q.size() != 0); i++) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all expected flits delivered", DW'(exp_q.size()), '0);
    chk(chain_q.size() == 0, "R3", "all chain flits delivered", DW'(chain_q.size()), '0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(o_valid == '0, "R9", "out_valid in reset", DW'(o_valid), '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(o_valid == '0, "R9", "out_valid after reset", DW'(o_valid), '0);
    chk(o_err == 1'b0, "R6", "err_flag after reset", DW'(o_err), '0);

    // R1/R2/R3: multi-flit messages to each output
    send_msg({2'd0, 30'h0ABCDEF1}, 3, 32'h1000_0000);
    send_msg({2'd2, 30'h15555555}, 2, 32'h2000_0000);
    send_msg({2'd1, 30'h3FFFFFFF}, 4, 32'h3000_0000);
    // R8: single-flit messages back to back
    send_msg({2'd2, 30'h00000123}, 0, '0);
    send_msg({2'd0, 30'h00000456}, 0, '0);
    send_msg({2'd1, 30'h00000789}, 1, 32'hCAFE_0000);
    drain();
    chk(o_err == 1'b0, "R6", "no error on valid routes", DW'(o_err), '0);

    // R7: header held under full backpressure
    hold = 1'b1;
    fork send_msg({2'd1, 30'h2468ACE}, 1, 32'h7000_0000); join_none
    repeat (3) begin
      @(negedge clk); #2;
      chk(o_valid == 3'b010, "R7", "held header valid", DW'(o_valid), 32'h2);
      chk(d_ready == 1'b0, "R7", "in_ready low while held", DW'(d_ready), '0);
    end
    hold = 1'b0;
    wait fork;
    drain();

    // R5/R6: out-of-range route field drops the whole message
    send_msg({2'd3, 30'h0000BEEF}, 3, 32'hDEAD_0000);
    repeat (2) @(negedge clk); #2;
    chk(o_err == 1'b1, "R6", "err_flag set by bad route", DW'(o_err), 32'd1);
    chk(exp_q.size() == 0, "R5", "dropped message produced nothing", DW'(exp_q.size()), '0);
    // R8: message after the drop is routed normally; R6 flag stays
    send_msg({2'd2, 30'h1111}, 1, 32'h4000_0000);
    drain();
    chk(o_err == 1'b1, "R6", "err_flag sticky", DW'(o_err), 32'd1);

    // R7: random backpressure across many messages
    bp = 1'b1;
    for (int m = 0; m < 20; m++) begin
      logic [1:0] p;
      p = 2'(m % NO);
      send_msg({p, 30'($urandom)}, m % 4, 32'($urandom));
    end
    drain();
    bp = 1'b0;

    // R1/R2: chain of three stages, route 1 -> 2 -> 0
    send_chain({2'd1, 2'd2, 2'd0, 26'h0ABCDE}, 2, 32'h5000_0000);
    send_chain({2'd1, 2'd2, 2'd0, 26'h3FFFFFF}, 0, '0);
    drain();
    chk(a_err == 1'b0 && b_err == 1'b0 && z_err == 1'b0, "R6", "chain no error",
        DW'({a_err, b_err, z_err}), '0);

    // R6: reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(o_err == 1'b0, "R6", "err_flag cleared by reset", DW'(o_err), '0);

    finish_run();
  end
endmodule